// File: doc/BRIEF.md
# EDO DRAM Pin-Level Device Model

This block is a synthesizable stand-in for an extended-data-out dynamic RAM, built as a target for verifying memory controllers. It samples the active-low row strobe, column strobe, write enable and output enable on a system clock. It also samples a multiplexed address and an input data byte. It keeps a small cell array, indexed by a row taken when the row strobe falls and a column taken when the column strobe falls. The row and column widths are parameters, so a scaled-down array can be used in simulation.

The data output follows extended-data-out rules. Read data stays driven after the column strobe returns high, so page reads can overlap. The output is switched off in four cases: when both strobes are high, when output enable is high, when write enable is low while the column strobe is low, and for the whole of a write cycle. The model covers early writes, late (write-enable-controlled) writes, read-modify-write, page cycles, row-only refresh, column-before-row refresh with an internal 9-bit row counter, and column-only cycles. A sequencer with five named states handles all of these cycle types: IDLE, ROW_OPEN, READ, WRITE and REFRESH.

The transitions are as follows. From IDLE, a row-strobe fall goes to REFRESH if the column strobe is low, and to ROW_OPEN otherwise. From ROW_OPEN, a column-strobe fall goes to WRITE if write enable is low, and to READ otherwise. READ returns to ROW_OPEN when the column strobe rises, and goes to WRITE when write enable falls (late write or read-modify-write). WRITE returns to ROW_OPEN when the column strobe rises. A row-strobe rise moves every state to IDLE.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, dout_en is 0. Whenever dout_en is 0, dout reads all zeros.
- R2: In a cycle with the row open, a column-strobe fall with write enable high and output enable low sets dout_en to 1 and dout to the cell {row, column}. The row is addr[ROW_W-1:0] at the row-strobe fall, the column is addr[COL_W-1:0] at the column-strobe fall, and the row forms the upper index bits.
- R3: While the row strobe stays low, the read data stays driven after the column strobe rises. A following column-strobe fall replaces it with the new column's cell (page read).
- R4: When the row strobe rises while the column strobe is still low, the data stays driven and unchanged. dout_en drops once both strobes are high.
- R5: A high output enable turns dout_en off. Lowering it again restores the same data, because the held data is not disturbed.
- R6: Early write: when write enable is low at the column-strobe fall, din is stored in the addressed cell and dout_en stays 0 for the whole cycle, even with output enable low.
- R7: Late write / read-modify-write: write enable falling while the column strobe is low in a read stores din at that edge into the cell latched at the column-strobe fall, and turns dout_en off.
- R8: A column-strobe pulse while the row strobe is high changes neither the cells nor the output state, whatever write enable and din are.
- R9: A row-strobe fall with the column strobe already low starts a refresh-only cycle. The cycle ignores address, write enable and din, keeps dout_en at 0, and advances an internal 9-bit row counter by one.
- R10: A row-only cycle (row strobe low, column strobe kept high) drives nothing and changes no cell.
- R11: Write enable low while the column strobe is low turns dout_en off, even while data is being held after the row strobe has risen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Output-driver enable |

## Verification
Every result is due one rising clock edge after the input pattern that causes it, because the sequencer state, the held data and the driver enable are all registered on the edge where the strobes are sampled. The bench changes inputs on the falling edge and checks dout and dout_en on the next falling edge, which is exactly one rising edge later. Each cycle step is therefore checked at the point where its effect must first appear. Effects on stored cells are checked by a later ordinary read that compares against a model array the bench keeps itself.

// File: rtl/edo_pkg.sv
package edo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ROW_OPEN = 3'd1,
        ST_READ     = 3'd2,
        ST_WRITE    = 3'd3,
        ST_REFRESH  = 3'd4
    } edo_state_t;
endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    output logic ras_fall,
    output logic cas_fall
);
    logic ras_q;
    logic cas_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    assign ras_fall = ras_q & ~ras_n;
    assign cas_fall = cas_q & ~cas_n;
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[idx] <= wr_data;
    end

    assign rd_data = cells[idx];
endmodule

// File: rtl/edo_sequencer.sv
module edo_sequencer
    import edo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int REF_W  = 9,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int IDX_W  = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ras_fall,
    input  logic              cas_fall,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] held_data,
    output logic              drive_en
);
    edo_state_t        st_q, st_nx;
    logic [ROW_W-1:0]  row_q, row_nx;
    logic [COL_W-1:0]  col_q, col_nx;
    logic [DATA_W-1:0] dlat_q, dlat_nx;
    logic              drv_q, drv_nx;
    logic              en_q;
    logic [REF_W-1:0]  cnt_q, cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            row_q  <= '0;
            col_q  <= '0;
            dlat_q <= '0;
            drv_q  <= 1'b0;
            en_q   <= 1'b0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_nx;
            row_q  <= row_nx;
            col_q  <= col_nx;
            dlat_q <= dlat_nx;
            drv_q  <= drv_nx;
            en_q   <= drv_nx & ~oe_n;
            cnt_q  <= cnt_nx;
        end
    end

    // next state and next output values
    always_comb begin
        st_nx   = st_q;
        row_nx  = row_q;
        col_nx  = col_q;
        dlat_nx = dlat_q;
        drv_nx  = drv_q;
        cnt_nx  = cnt_q;
        wr_en   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (!cas_n) begin
                        st_nx  = ST_REFRESH;
                        cnt_nx = cnt_q + REF_W'(1);
                        drv_nx = 1'b0;
                    end else begin
                        st_nx  = ST_ROW_OPEN;
                        row_nx = addr[ROW_W-1:0];
                    end
                end
            end
            ST_ROW_OPEN: begin
                if (ras_n) begin
                    st_nx = ST_IDLE;
                end else if (cas_fall) begin
                    col_nx = addr[COL_W-1:0];
                    if (!we_n) begin
                        st_nx  = ST_WRITE;
                        wr_en  = 1'b1;
                        drv_nx = 1'b0;
                    end else begin
                        st_nx   = ST_READ;
                        dlat_nx = rd_data;
                        drv_nx  = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (ras_n) begin
                    st_nx = ST_IDLE;
                end else if (cas_n) begin
                    st_nx = ST_ROW_OPEN;
                end else if (!we_n) begin
                    st_nx  = ST_WRITE;
                    wr_en  = 1'b1;
                    drv_nx = 1'b0;
                end
            end
            ST_WRITE: begin
                if (ras_n)      st_nx = ST_IDLE;
                else if (cas_n) st_nx = ST_ROW_OPEN;
            end
            ST_REFRESH: begin
                if (ras_n) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
        if (ras_n && cas_n) drv_nx = 1'b0;
        if (!we_n && !cas_n) drv_nx = 1'b0;
    end

    // outputs
    always_comb begin
        idx       = (st_q == ST_READ) ? {row_q, col_q} : {row_q, addr[COL_W-1:0]};
        held_data = dlat_q;
        drive_en  = en_q;
    end

    p_both_high_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && cas_n) |=> !en_q);
    p_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !en_q);
    p_we_cas_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !cas_n) |=> !en_q);
    p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WRITE) |-> !en_q);
    p_refresh_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REFRESH) |-> !en_q);
    p_refresh_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && ras_fall && !cas_n) |=> (cnt_q == $past(cnt_q) + REF_W'(1)));
    p_cas_only_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && ras_n) |=> $stable(dlat_q));
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
    parameter int DATA_W = 8,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int REF_W  = 9,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int IDX_W = ROW_W + COL_W;

    logic              ras_fall, cas_fall, wr_en, drive_en;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_data, held_data;

    edo_strobe_sampler u_sampler (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .ras_fall(ras_fall), .cas_fall(cas_fall)
    );

    edo_cell_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .wr_en(wr_en), .idx(idx), .wr_data(din), .rd_data(rd_data)
    );

    edo_sequencer #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .REF_W(REF_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .ras_fall(ras_fall), .cas_fall(cas_fall),
        .rd_data(rd_data), .wr_en(wr_en), .idx(idx), .held_data(held_data),
        .drive_en(drive_en)
    );

    assign dout_en = drive_en;
    assign dout    = drive_en ? held_data : '0;

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));
endmodule

// File: tb/tb_edo_dram_model.sv
module tb_edo_dram_model;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] model [256];

    edo_dram_model dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #2 clk = ~clk;

    task automatic drive(input logic r, input logic c, input logic w, input logic o,
                         input logic [3:0] a, input logic [7:0] d);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic en, input logic [7:0] val);
        n_run++;
        if ({dout_en, dout} !== {en, val}) begin
            n_fail++;
            $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
                     req, dout_en, dout, en, val);
        end
    endtask

    task automatic early_write(input logic [3:0] row, input logic [3:0] col, input logic [7:0] d);
        drive(0, 1, 1, 0, row, 8'h00); expect_out("R6 row open", 0, 8'h00);
        drive(0, 0, 0, 0, col, d);     expect_out("R6 early write hi-z", 0, 8'h00);
        drive(0, 1, 1, 0, col, d);     expect_out("R6 after cas", 0, 8'h00);
        drive(1, 1, 1, 0, 4'h0, 8'h00);
        model[{row, col}] = d;
    endtask

    task automatic read_cell(input string req, input logic [3:0] row, input logic [3:0] col);
        drive(0, 1, 1, 0, row, 8'h00);
        drive(0, 0, 1, 0, col, 8'h00); expect_out({req, " R2 read"}, 1, model[{row, col}]);
        drive(0, 1, 1, 0, col, 8'h00); expect_out("R3 hold after cas", 1, model[{row, col}]);
        drive(1, 1, 1, 0, 4'h0, 8'h00); expect_out("R4 both high off", 0, 8'h00);
    endtask

    task automatic t_page();
        drive(0, 1, 1, 0, 4'h3, 8'h00);
        drive(0, 0, 1, 0, 4'h1, 8'h00); expect_out("R2 page first", 1, model[8'h31]);
        drive(0, 1, 1, 0, 4'h1, 8'h00); expect_out("R3 page hold", 1, model[8'h31]);
        drive(0, 0, 1, 0, 4'h9, 8'h00); expect_out("R3 page second", 1, model[8'h39]);
        drive(0, 1, 1, 0, 4'h9, 8'h00); expect_out("R3 page hold2", 1, model[8'h39]);
        drive(1, 1, 1, 0, 4'h0, 8'h00); expect_out("R4 page close", 0, 8'h00);
    endtask

    task automatic t_ras_first();
        drive(0, 1, 1, 0, 4'h5, 8'h00);
        drive(0, 0, 1, 0, 4'hC, 8'h00);
        drive(1, 0, 1, 0, 4'h0, 8'h00); expect_out("R4 ras rise keeps data", 1, model[8'h5C]);
        drive(1, 1, 1, 0, 4'h0, 8'h00); expect_out("R4 both high", 0, 8'h00);
    endtask

    task automatic t_oe();
        drive(0, 1, 1, 0, 4'hA, 8'h00);
        drive(0, 0, 1, 0, 4'h2, 8'h00); expect_out("R5 read", 1, model[8'hA2]);
        drive(0, 0, 1, 1, 4'h2, 8'h00); expect_out("R5 oe high off", 0, 8'h00);
        drive(0, 1, 1, 1, 4'h2, 8'h00); expect_out("R5 oe high cas up", 0, 8'h00);
        drive(0, 1, 1, 0, 4'h2, 8'h00); expect_out("R5 oe low restores", 1, model[8'hA2]);
        drive(1, 1, 1, 0, 4'h0, 8'h00); expect_out("R4 close", 0, 8'h00);
    endtask

    task automatic t_rmw();
        drive(0, 1, 1, 0, 4'h7, 8'h00);
        drive(0, 0, 1, 0, 4'h4, 8'h00); expect_out("R7 read part", 1, model[8'h74]);
        drive(0, 0, 1, 1, 4'h4, 8'h00); expect_out("R7 oe raised", 0, 8'h00);
        drive(0, 0, 0, 1, 4'hF, 8'h6E); expect_out("R7 write part off", 0, 8'h00);
        drive(0, 0, 0, 0, 4'hF, 8'h11); expect_out("R7 stays off", 0, 8'h00);
        drive(0, 1, 1, 0, 4'h0, 8'h00);
        drive(1, 1, 1, 0, 4'h0, 8'h00);
        model[8'h74] = 8'h6E;
        read_cell("R7 readback", 4'h7, 4'h4);
    endtask

    task automatic t_cas_only();
        drive(1, 0, 0, 0, 4'h4, 8'h77); expect_out("R8 cas-only no drive", 0, 8'h00);
        drive(1, 1, 1, 0, 4'h4, 8'h77); expect_out("R8 cas-only end", 0, 8'h00);
        read_cell("R8 cell untouched", 4'h7, 4'h4);
    endtask

    task automatic t_cbr();
        drive(1, 0, 1, 0, 4'h0, 8'h00);
        drive(0, 0, 0, 0, 4'h3, 8'h99); expect_out("R9 refresh hi-z", 0, 8'h00);
        drive(0, 0, 0, 0, 4'h3, 8'h99); expect_out("R9 refresh hold", 0, 8'h00);
        drive(1, 0, 1, 0, 4'h0, 8'h00);
        drive(1, 1, 1, 0, 4'h0, 8'h00); expect_out("R9 end", 0, 8'h00);
        read_cell("R9 cell untouched", 4'h3, 4'h1);
        drive(0, 1, 1, 0, 4'h5, 8'h00);
        drive(0, 0, 1, 0, 4'hC, 8'h00);
        drive(1, 0, 1, 0, 4'h0, 8'h00); expect_out("R4 held before refresh", 1, model[8'h5C]);
        drive(0, 0, 1, 0, 4'h0, 8'h00); expect_out("R9 refresh after hold off", 0, 8'h00);
        drive(1, 0, 1, 0, 4'h0, 8'h00);
        drive(1, 1, 1, 0, 4'h0, 8'h00);
    endtask

    task automatic t_ras_only();
        drive(0, 1, 0, 0, 4'h3, 8'hEE); expect_out("R10 ras-only no drive", 0, 8'h00);
        drive(0, 1, 0, 0, 4'h9, 8'hEE); expect_out("R10 ras-only hold", 0, 8'h00);
        drive(1, 1, 1, 0, 4'h0, 8'h00);
        read_cell("R10 cell untouched", 4'h3, 4'h9);
    endtask

    task automatic t_we_disable();
        drive(0, 1, 1, 0, 4'hA, 8'h00);
        drive(0, 0, 1, 0, 4'h2, 8'h00);
        drive(1, 0, 1, 0, 4'h0, 8'h00); expect_out("R11 held", 1, model[8'hA2]);
        drive(1, 0, 0, 0, 4'h0, 8'h00); expect_out("R11 we low off", 0, 8'h00);
        drive(1, 1, 1, 0, 4'h0, 8'h00);
        read_cell("R11 cell untouched", 4'hA, 4'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 reset", 0, 8'h00);
        early_write(4'h3, 4'h1, 8'hA5);
        early_write(4'h3, 4'h9, 8'h3C);
        early_write(4'h5, 4'hC, 8'hFF);
        early_write(4'hA, 4'h2, 8'h00);
        early_write(4'h7, 4'h4, 8'h5A);
        read_cell("R6 readback", 4'h3, 4'h1);
        read_cell("R6 readback", 4'h5, 4'hC);
        read_cell("R6 readback", 4'hA, 4'h2);
        t_page();
        t_ras_first();
        t_oe();
        t_rmw();
        t_cas_only();
        t_cbr();
        t_ras_only();
        t_we_disable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule